// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block produces pulse-width modulated waveforms on several independent outputs. Each channel has its own small set of memory-mapped registers. In every channel, a prescaler first divides the system clock by a factor taken from a fixed ladder of eight values. A period counter then steps on each prescaled tick from zero up to a programmed terminal count and wraps back to zero. The output is in its active state while the counter is below a programmed duty count. A control bit can invert the sense of the output.

Software writes the duty, terminal count and prescale code at any time. A running channel does not use new timing values straight away. It adopts them at the next period wrap, so every period it emits is whole and consistent. Clearing a channel's enable bit stops it at once and parks its output at the idle level. The read port returns whatever was last written to each register.

Top module: `pwm_bank_ctrl`

## Requirements
- R1: After reset every register reads zero, every channel is stopped and every output is low.
- R2: Channel n's registers start at byte address n*0x10. Word index 0 (offset 0x0) is enable, 1 (0x4) is control, 2 (0x8) is duty and 3 (0xC) is terminal count. Address bits [1:0] are ignored. A read returns the last value written, masked to the implemented bits: enable bit 0, control bits [3:0], and duty and terminal count bits [15:0]. All other bits read zero. A write to one channel leaves the other channels unchanged.
- R3: Control bits [2:0] choose the prescale factor. Codes 0 through 7 select 1, 4, 8, 16, 64, 256, 1024 and 4096. Each counter value lasts exactly that many clock cycles.
- R4: The period counter runs from 0 up to and including the terminal count, then wraps to 0. A period is therefore (terminal count + 1) × factor cycles, for terminal counts from 0 up to 65535.
- R5: An enabled channel is active while its counter is strictly below the duty count. A duty of 0 is never active. A duty above the terminal count is always active.
- R6: When control bit 3 is set, the output is the inverse of the active state. This bit takes effect in the cycle after the write, without waiting for a period wrap.
- R7: Enable bit 0 starts the channel. When it is cleared, the counter and prescaler are held at zero and the output sits at the inactive level, which is high when the output is inverted and low otherwise. A channel that is enabled shows counter value 0 in the first cycle after the write.
- R8: While a channel runs, new duty, terminal count and prescale values take effect only at the next period wrap. A write that lands on the wrap edge itself waits for the following wrap. While a channel is disabled, new values are adopted directly.
- R9: The channels run independently. Each channel's output depends only on its own registers and on the time since it was enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the same cycle as a read strobe, zero otherwise |
| pwm_out | output | NUM_CH (4) | One modulated output per channel |

## Verification
The delicate collision is a register write that lands on the same clock edge as the period wrap. The wrap loads the shadow values, while the write changes the programmed value, and both happen in that one cycle. The bench provokes this by stepping a running channel until its elapsed cycle count sits one before a multiple of the period, then issuing a duty write. The output is judged against the old duty for a whole further period and against the new one only after the next wrap. Writes in mid-period and changes to terminal count and prescale code also run against a live counter. For those, the bench moves its reference phase to the wrap it expects.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   // word index of each register inside a channel bank
   localparam logic [1:0] REG_EN   = 2'd0;
   localparam logic [1:0] REG_CTRL = 2'd1;
   localparam logic [1:0] REG_DUTY = 2'd2;
   localparam logic [1:0] REG_TC   = 2'd3;

   localparam int BANK_LSB   = 4;   // 0x10 bytes per channel
   localparam int IDX_LSB    = 2;   // 32-bit word registers
   localparam int CTRL_W     = 4;
   localparam int PRE_CODE_W = 3;
   localparam int PRE_MIN_W  = 12;  // largest factor is 2**12

   typedef struct packed {
      logic                  inv;
      logic [PRE_CODE_W-1:0] code;
   } ctrl_t;

   // exponent of two for each prescale code: 1,4,8,16,64,256,1024,4096
   function automatic logic [3:0] presc_shift(input logic [PRE_CODE_W-1:0] code);
      logic [3:0] s;
      case (code)
         3'd0:    s = 4'd0;
         3'd1:    s = 4'd2;
         3'd2:    s = 4'd3;
         3'd3:    s = 4'd4;
         3'd4:    s = 4'd6;
         3'd5:    s = 4'd8;
         3'd6:    s = 4'd10;
         default: s = 4'd12;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/pwm_reg_bank.sv
module pwm_reg_bank
   import pwm_bank_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              en,
   output ctrl_t             ctrl,
   output logic [CNT_W-1:0]  duty,
   output logic [CNT_W-1:0]  tc
);

   if (DATA_W < CNT_W) begin : g_bad_width
      $error("pwm_reg_bank: DATA_W must hold a CNT_W count");
   end
   if (DATA_W < CTRL_W) begin : g_bad_ctrl
      $error("pwm_reg_bank: DATA_W too narrow for control word");
   end

   logic wdata_unused;
   assign wdata_unused = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= 1'b0;
         ctrl <= '0;
         duty <= '0;
         tc   <= '0;
      end else if (wr_en) begin
         case (idx)
            REG_EN:   en   <= wdata[0];
            REG_CTRL: ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
            REG_DUTY: duty <= wdata[CNT_W-1:0];
            default:  tc   <= wdata[CNT_W-1:0];
         endcase
      end
   end

   always_comb begin
      case (idx)
         REG_EN:   rdata = DATA_W'(en);
         REG_CTRL: rdata = DATA_W'(ctrl);
         REG_DUTY: rdata = DATA_W'(duty);
         default:  rdata = DATA_W'(tc);
      endcase
   end

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
   import pwm_bank_pkg::*;
#(
   parameter int PRE_W = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic [PRE_CODE_W-1:0] code,
   output logic                  tick
);

   if (PRE_W < PRE_MIN_W) begin : g_bad_pre
      $error("pwm_prescaler: PRE_W cannot reach the largest factor");
   end

   logic [PRE_W-1:0] cnt_q;
   logic [PRE_W-1:0] limit;
   logic [PRE_W:0]   span;

   always_comb begin
      span  = (PRE_W+1)'(1) << presc_shift(code);
      limit = span[PRE_W-1:0] - PRE_W'(1);
   end

   assign tick = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + PRE_W'(1);
   end

endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core
   import pwm_bank_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic                  tick,
   input  logic [CNT_W-1:0]      duty_in,
   input  logic [CNT_W-1:0]      tc_in,
   input  logic [PRE_CODE_W-1:0] code_in,
   output logic [PRE_CODE_W-1:0] code_act,
   output logic [CNT_W-1:0]      cnt,
   output logic [CNT_W-1:0]      tc_act,
   output logic                  active
);

   logic [CNT_W-1:0] duty_act;
   logic             wrap;

   assign wrap = tick && (cnt == tc_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         duty_act <= '0;
         tc_act   <= '0;
         code_act <= '0;
      end else if (!run) begin
         cnt      <= '0;
         duty_act <= duty_in;
         tc_act   <= tc_in;
         code_act <= code_in;
      end else begin
         if (tick)
            cnt <= wrap ? '0 : cnt + CNT_W'(1);
         if (wrap) begin
            duty_act <= duty_in;
            tc_act   <= tc_in;
            code_act <= code_in;
         end
      end
   end

   assign active = run && (cnt < duty_act);

endmodule

// File: rtl/pwm_bank_ctrl.sv
module pwm_bank_ctrl
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6,
   parameter int PRE_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] pwm_out
);

   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int DEC_HI = BANK_LSB + CH_W;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("pwm_bank_ctrl: NUM_CH must be at least 1");
   end
   if (ADDR_W < DEC_HI) begin : g_bad_addr
      $error("pwm_bank_ctrl: ADDR_W cannot reach every channel bank");
   end

   logic [CH_W-1:0]              ch_sel;
   logic [1:0]                   reg_idx;
   logic                         hi_ok;
   logic                         addr_lo_unused;
   logic [NUM_CH-1:0]            ch_en;
   logic [NUM_CH-1:0]            ch_inv;
   logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt;
   logic [NUM_CH-1:0][CNT_W-1:0] ch_act_tc;
   logic [NUM_CH-1:0][DATA_W-1:0] ch_rdata;

   assign ch_sel         = bus_addr[BANK_LSB +: CH_W];
   assign reg_idx        = bus_addr[IDX_LSB +: 2];
   assign addr_lo_unused = ^bus_addr[IDX_LSB-1:0];

   if (ADDR_W > DEC_HI) begin : g_hi_dec
      assign hi_ok = ~|bus_addr[ADDR_W-1:DEC_HI];
   end else begin : g_hi_none
      assign hi_ok = 1'b1;
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      ctrl_t                 ctrl;
      logic [CNT_W-1:0]      duty;
      logic [CNT_W-1:0]      tc;
      logic [PRE_CODE_W-1:0] code_act;
      logic                  tick;
      logic                  active;
      logic                  hit;

      assign hit = bus_sel && bus_wr && hi_ok && (ch_sel == CH_W'(i));

      pwm_reg_bank #(
         .CNT_W  (CNT_W),
         .DATA_W (DATA_W)
      ) i_regs (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (hit),
         .idx   (reg_idx),
         .wdata (bus_wdata),
         .rdata (ch_rdata[i]),
         .en    (ch_en[i]),
         .ctrl  (ctrl),
         .duty  (duty),
         .tc    (tc)
      );

      pwm_prescaler #(
         .PRE_W (PRE_W)
      ) i_pre (
         .clk   (clk),
         .rst_n (rst_n),
         .run   (ch_en[i]),
         .code  (code_act),
         .tick  (tick)
      );

      pwm_period_core #(
         .CNT_W (CNT_W)
      ) i_core (
         .clk      (clk),
         .rst_n    (rst_n),
         .run      (ch_en[i]),
         .tick     (tick),
         .duty_in  (duty),
         .tc_in    (tc),
         .code_in  (ctrl.code),
         .code_act (code_act),
         .cnt      (ch_cnt[i]),
         .tc_act   (ch_act_tc[i]),
         .active   (active)
      );

      assign ch_inv[i]  = ctrl.inv;
      assign pwm_out[i] = active ^ ch_inv[i];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr && hi_ok) begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (ch_sel == CH_W'(i))
               bus_rdata = ch_rdata[i];
         end
      end
   end

endmodule

// File: rtl/pwm_bank_ctrl_chk.sv
module pwm_bank_ctrl_chk #(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         bus_sel,
   input logic                         bus_wr,
   input logic [ADDR_W-1:0]            bus_addr,
   input logic [DATA_W-1:0]            bus_rdata,
   input logic [NUM_CH-1:0]            pwm_out,
   input logic [NUM_CH-1:0]            ch_en,
   input logic [NUM_CH-1:0]            ch_inv,
   input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
   input logic [NUM_CH-1:0][CNT_W-1:0] ch_act_tc
);

   assert_en_read_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr[3:2] == 2'd0) |-> (bus_rdata[DATA_W-1:1] == '0));

   assert_ctrl_read_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr[3:2] == 2'd1) |-> (bus_rdata[DATA_W-1:4] == '0));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_en[i] |-> (pwm_out[i] == ch_inv[i]));

      assert_idle_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_en[i] |=> (ch_cnt[i] == '0));

      assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
         ch_cnt[i] <= ch_act_tc[i]);

      assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_cnt[i] != $past(ch_cnt[i])) |->
            ((ch_cnt[i] == $past(ch_cnt[i]) + CNT_W'(1)) || (ch_cnt[i] == '0)));
   end

endmodule

bind pwm_bank_ctrl pwm_bank_ctrl_chk #(
   .NUM_CH (NUM_CH),
   .CNT_W  (CNT_W),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .pwm_out   (pwm_out),
   .ch_en     (ch_en),
   .ch_inv    (ch_inv),
   .ch_cnt    (ch_cnt),
   .ch_act_tc (ch_act_tc)
);

// File: tb/test_pwm_bank_ctrl.sv
module test_pwm_bank_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  pwm_out;

   int nvec = 0;
   int nbad = 0;
   int cyc  = 0;
   int en_cyc [4];
   int cf_f   [4];
   int cf_tc  [4];
   int cf_duty[4];
   bit cf_inv [4];
   bit cf_en  [4];

   pwm_bank_ctrl i_pwm_bank_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pwm_out   (pwm_out)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int factor(input int code);
      case (code)
         0: return 1;    1: return 4;    2: return 8;    3: return 16;
         4: return 64;   5: return 256;  6: return 1024; default: return 4096;
      endcase
   endfunction

   function automatic int adr(input int ch, input int r);
      return ch * 16 + r * 4;
   endfunction

   function automatic bit exp_out(input int ch);
      int e, c;
      if (!cf_en[ch]) return cf_inv[ch];
      e = cyc - en_cyc[ch];
      c = (e / cf_f[ch]) % (cf_tc[ch] + 1);
      return (c < cf_duty[ch]) ^ cf_inv[ch];
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      nvec++;
      if (got !== exp) begin
         nbad++;
         $display("FAIL %s at cycle %0d: got %h expected %h", req, cyc, got, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'(a);
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic run_all(input int n, input string req);
      for (int k = 0; k < n; k++) begin
         for (int ch = 0; ch < 4; ch++)
            chk(req, 32'(pwm_out[ch]), 32'(exp_out(ch)));
         @(negedge clk);
      end
   endtask

   task automatic run_until(input int ch, input int m, input int r, input string req);
      while (((cyc - en_cyc[ch]) % m) != r)
         run_all(1, req);
   endtask

   task automatic cfg(input int ch, input int code, input bit inv, input int tc, input int duty);
      wr(adr(ch, 0), 0);
      cf_en[ch] = 1'b0;
      wr(adr(ch, 1), {28'd0, inv, 3'(code)});
      wr(adr(ch, 3), 32'(tc));
      wr(adr(ch, 2), 32'(duty));
      wr(adr(ch, 0), 1);
      en_cyc[ch] = cyc;
      cf_en[ch] = 1'b1; cf_f[ch] = factor(code); cf_inv[ch] = inv;
      cf_tc[ch] = tc; cf_duty[ch] = duty;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] d;
      int unsigned seed_val;
      for (int ch = 0; ch < 4; ch++) begin
         en_cyc[ch] = 0; cf_f[ch] = 1; cf_tc[ch] = 0; cf_duty[ch] = 0;
         cf_inv[ch] = 0; cf_en[ch] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 outputs", 32'(pwm_out), 32'h0);
      for (int ch = 0; ch < 4; ch++)
         for (int r = 0; r < 4; r++) begin
            rd(adr(ch, r), d);
            chk("R1 register", d, 32'h0);
         end

      // R2: readback masks, address map, ignored low bits
      wr(adr(2, 1), 32'hFFFF_FFFF);
      chk("R7 idle level inverted", 32'(pwm_out[2]), 32'h1);
      rd(adr(2, 1), d); chk("R2 control", d, 32'hF);
      wr(adr(2, 2), 32'hABCD_1234);
      rd(adr(2, 2), d); chk("R2 duty", d, 32'h1234);
      wr(adr(2, 2) + 3, 32'h77);
      rd(adr(2, 2), d); chk("R2 low address bits", d, 32'h77);
      wr(adr(2, 3), 32'h5555_FFFF);
      rd(adr(2, 3), d); chk("R2 terminal count", d, 32'hFFFF);
      wr(adr(2, 0), 32'hFFFF_FFFE);
      rd(adr(2, 0), d); chk("R2 enable clear", d, 32'h0);
      chk("R7 still idle", 32'(pwm_out[2]), 32'h1);
      wr(adr(2, 0), 32'h3);
      rd(adr(2, 0), d); chk("R2 enable set", d, 32'h1);
      rd(adr(1, 2), d); chk("R2 neighbour untouched", d, 32'h0);
      wr(adr(2, 0), 0);
      wr(adr(2, 1), 0);
      chk("R7 idle level normal", 32'(pwm_out[2]), 32'h0);

      // R3: prescale ladder on channel 0, two-tick period with one tick active
      for (int code = 0; code < 8; code++) begin
         cfg(0, code, 1'b0, 1, 1);
         run_all(4 * factor(code), "R3 prescale");
      end

      // R4/R5: count boundaries on channel 1
      cfg(1, 0, 1'b0, 0, 1);      run_all(20, "R5 duty above single-tick period");
      cfg(1, 0, 1'b0, 0, 0);      run_all(20, "R5 zero duty");
      cfg(1, 0, 1'b0, 5, 6);      run_all(20, "R5 duty above terminal count");
      cfg(1, 0, 1'b0, 5, 5);      run_all(20, "R4 period six");
      cfg(1, 0, 1'b0, 65535, 65535);
      run_all(65540, "R4 maximum terminal count");

      // R8: shadowed updates on a live channel
      cfg(1, 0, 1'b0, 9, 3);
      run_all(12, "R8 base");
      run_until(1, 10, 2, "R8 base");
      wr(adr(1, 2), 7);
      run_until(1, 10, 0, "R8 old duty until wrap");
      cf_duty[1] = 7;
      run_all(25, "R8 new duty after wrap");
      run_until(1, 10, 9, "R8 before wrap edge");
      wr(adr(1, 2), 2);           // lands on the wrap edge
      run_all(10, "R8 write on wrap edge deferred");
      cf_duty[1] = 2;
      run_all(20, "R8 deferred duty applied");
      run_until(1, 10, 4, "R8 before tc write");
      wr(adr(1, 3), 4);
      run_until(1, 10, 0, "R8 old terminal count");
      en_cyc[1] = cyc; cf_tc[1] = 4;
      run_all(15, "R8 new terminal count");
      run_until(1, 5, 2, "R8 before prescale write");
      wr(adr(1, 1), 1);
      run_until(1, 5, 0, "R8 old prescale");
      en_cyc[1] = cyc; cf_f[1] = 4;
      run_all(45, "R8 new prescale");

      // R6: inversion applies at once
      run_until(1, 20, 7, "R6 before invert");
      wr(adr(1, 1), 32'h9);
      cf_inv[1] = 1'b1;
      run_all(40, "R6 inverted output");

      // R7: disable mid-run, then restart from zero
      run_until(1, 20, 11, "R7 before disable");
      wr(adr(1, 0), 0);
      cf_en[1] = 1'b0;
      run_all(6, "R7 disabled inactive level");
      wr(adr(1, 0), 1);
      en_cyc[1] = cyc; cf_en[1] = 1'b1;
      run_all(30, "R7 restart from count zero");

      // R8: values written while disabled are used from the first cycle
      wr(adr(1, 0), 0);
      cf_en[1] = 1'b0;
      wr(adr(1, 2), 1);
      wr(adr(1, 3), 2);
      wr(adr(1, 1), 0);
      wr(adr(1, 0), 1);
      en_cyc[1] = cyc; cf_en[1] = 1'b1; cf_duty[1] = 1; cf_tc[1] = 2;
      cf_f[1] = 1; cf_inv[1] = 1'b0;
      run_all(12, "R8 adopted while disabled");

      // R9: random independent channels
      seed_val = $urandom(32'd7781);
      for (int round = 0; round < 3; round++) begin
         for (int ch = 0; ch < 4; ch++)
            cfg(ch, int'($urandom_range(0, 2)), 1'($urandom_range(0, 1)),
                int'($urandom_range(0, 15)), int'($urandom_range(0, 17)));
         run_all(300, "R9 independent channels");
      end

      summary();
      $finish;
   end

endmodule